// File: doc/BRIEF.md
# Write-Completion Status Read Generator

This block sits in the read path of a self-timed nonvolatile memory. While the memory runs its internal program or erase cycle, the array cannot return stored data. During that time the block drives a status byte onto the read data instead, so a host can poll the same location until the operation ends.

Two polling methods are supported. In the polarity method, bit 7 returns the inverse of bit 7 of the last byte loaded, and it returns to the true value once programming finishes. In the toggle method, bit 6 changes state after every completed read while the cycle runs.

After the busy flag drops, bit 7 shows real array data at once. The remaining bits stay masked for a settling window of `SETTLE_CYCLES` clocks. After that window, the read data passes the array through unchanged.

Top module: `wcsr_status_read`

## Requirements
- R1: When idle (not busy and not in the settling window), `rdData` equals `arrayData` in every bit.
- R2: While `busy` is high and `opErase` is low, bit 7 of `rdData` is the inverse of `loadedMsb`.
- R3: While busy, bit 6 of `rdData` inverts one clock after each completed read (a high-to-low transition of `rdEn`). It holds its value while `rdEn` stays high or stays low.
- R4: The first bit-6 value returned after `busy` rises is 1. This holds whatever reads took place while idle.
- R5: While `busy` is high and `opErase` is high, bit 7 of `rdData` reads 0 and bit 6 toggles as in R3.
- R6: While busy, bits 5 down to 0 of `rdData` read 0.
- R7: The status byte appears in the same cycle that `busy` is first seen high, with no clock of latency.
- R8: From the cycle `busy` falls through the next `SETTLE_CYCLES` clock edges, bit 7 of `rdData` equals bit 7 of `arrayData`, and bits 6 to 0 read 0 (so bit 6 no longer toggles). After the following edge, R1 applies.
- R9: With `rstN` low, the toggle state is preset to 1 and no settling window is pending. With `busy` low, `rdData` equals `arrayData`.
- R10: If `busy` rises again during a settling window, the window ends at once and the status byte is returned, with bit 6 starting at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Internal write or erase cycle in progress |
| opErase | input | 1 | Running operation is a whole-array erase (1) or a page write (0) |
| loadedMsb | input | 1 | Bit 7 of the most recent byte loaded before the write began |
| rdEn | input | 1 | Read strobe; a read completes when it goes from high to low |
| arrayData | input | DATA_W | Normal read data from the array |
| rdData | output | DATA_W | Read data returned to the host |

## Verification
The bench builds the block with `DATA_W` = 8 and `SETTLE_CYCLES` = 6. The short window lets each polling pass run to completion within a few clocks. It also lets the bench observe both ends of the settling interval, which are the last masked cycle and the first pass-through cycle. The window is also short enough to re-raise busy while a window is still open. Each table entry starts a write or erase and performs held and completed reads. It then lowers busy and checks the masked and unmasked data.

// File: rtl/wcsr_pkg.sv
package wcsr_pkg;

  typedef enum logic [1:0] {
    SEL_ARRAY      = 2'd0,
    SEL_SETTLE     = 2'd1,
    SEL_POLL_WRITE = 2'd2,
    SEL_POLL_ERASE = 2'd3
  } outSel_e;

  typedef struct packed {
    logic    togPreset;
    logic    togFlip;
    outSel_e outSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/wcsr_ctrl.sv
module wcsr_ctrl
  import wcsr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 200
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busy,
  input  logic         opErase,
  input  logic         rdEn,
  output ctrlStrobes_t strobes
);

  logic busyQ;
  logic rdEnQ;
  logic busyFall;
  logic settling;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      rdEnQ <= 1'b0;
    end else begin
      busyQ <= busy;
      rdEnQ <= rdEn;
    end
  end

  assign busyFall = busyQ && !busy;

  generate
    if (SETTLE_CYCLES > 0) begin : g_settle
      localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);
      logic [CNT_W-1:0] settleCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          settleCnt <= '0;
        end else if (busy) begin
          settleCnt <= '0;
        end else if (busyFall) begin
          settleCnt <= CNT_LOAD;
        end else if (settleCnt != '0) begin
          settleCnt <= settleCnt - 1'b1;
        end
      end

      assign settling = busyFall || (settleCnt != '0);
    end else begin : g_noSettle
      assign settling = 1'b0;
    end
  endgenerate

  always_comb begin
    strobes.togPreset = !busy;
    strobes.togFlip   = busy && rdEnQ && !rdEn;
    if (busy) begin
      strobes.outSel = opErase ? SEL_POLL_ERASE : SEL_POLL_WRITE;
    end else if (settling) begin
      strobes.outSel = SEL_SETTLE;
    end else begin
      strobes.outSel = SEL_ARRAY;
    end
  end

endmodule

// File: rtl/wcsr_datapath.sv
module wcsr_datapath
  import wcsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              loadedMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic togBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togBit <= 1'b1;
    end else if (strobes.togPreset) begin
      togBit <= 1'b1;
    end else if (strobes.togFlip) begin
      togBit <= ~togBit;
    end
  end

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
        always_comb begin
          unique case (strobes.outSel)
            SEL_ARRAY:      rdData[i] = arrayData[i];
            SEL_SETTLE:     rdData[i] = arrayData[i];
            SEL_POLL_WRITE: rdData[i] = ~loadedMsb;
            default:        rdData[i] = 1'b0;
          endcase
        end
      end else if (i == TOG_BIT) begin : g_tog
        always_comb begin
          unique case (strobes.outSel)
            SEL_ARRAY:  rdData[i] = arrayData[i];
            SEL_SETTLE: rdData[i] = 1'b0;
            default:    rdData[i] = togBit;
          endcase
        end
      end else begin : g_plain
        always_comb begin
          rdData[i] = (strobes.outSel == SEL_ARRAY) ? arrayData[i] : 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wcsr_status_read.sv
module wcsr_status_read
  import wcsr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SETTLE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              opErase,
  input  logic              loadedMsb,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobes_t strobes;

  wcsr_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busy    (busy),
    .opErase (opErase),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  wcsr_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadedMsb (loadedMsb),
    .arrayData (arrayData),
    .rdData    (rdData)
  );

endmodule

// File: rtl/wcsr_status_read_chk.sv
module wcsr_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              opErase,
  input logic              loadedMsb,
  input logic              rdEn,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] rdData
);

  AST_WRITE_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opErase) |-> (rdData[DATA_W-1] == ~loadedMsb)); // R2

  AST_ERASE_MSB_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opErase) |-> !rdData[DATA_W-1]); // R5

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rdData[DATA_W-3:0] == '0)); // R6

  AST_FIRST_TOGGLE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy)) |-> rdData[DATA_W-2]); // R4

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(rstN, 2) && $past(rdEn, 2) && !$past(rdEn))
      |-> (rdData[DATA_W-2] != $past(rdData[DATA_W-2]))); // R3

  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(rstN, 2) && !($past(rdEn, 2) && !$past(rdEn)))
      |-> (rdData[DATA_W-2] == $past(rdData[DATA_W-2]))); // R3

  AST_IDLE_MSB_TRUE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rdData[DATA_W-1] == arrayData[DATA_W-1])); // R8

endmodule

bind wcsr_status_read wcsr_status_read_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/wcsr_status_read_tb.sv
module wcsr_status_read_tb;

  localparam int DATA_W = 8;
  localparam int SETTLE = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busy = 1'b0;
  logic       opErase = 1'b0;
  logic       loadedMsb = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  wcsr_status_read #(
    .DATA_W(DATA_W),
    .SETTLE_CYCLES(SETTLE)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .opErase   (opErase),
    .loadedMsb (loadedMsb),
    .rdEn      (rdEn),
    .arrayData (arrayData),
    .rdData    (rdData)
  );

  // {erase, loaded byte, array byte, status on first read, status after one completed read}
  localparam logic [32:0] VEC [0:5] = '{
    {1'b0, 8'h80, 8'h5A, 8'h40, 8'h00},
    {1'b0, 8'h12, 8'hC3, 8'hC0, 8'h80},
    {1'b1, 8'hFF, 8'hFF, 8'h40, 8'h00},
    {1'b1, 8'h00, 8'h81, 8'h40, 8'h00},
    {1'b0, 8'h7F, 8'h00, 8'hC0, 8'h80},
    {1'b0, 8'hFE, 8'hA5, 8'h40, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: rdData=%02h expected %02h", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: rdData=%02h expected run to finish", rdData);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    arrayData = 8'h3C;
    tick(3);
    check("R9 reset pass-through", rdData, 8'h3C);
    rstN = 1'b1;
    tick(2);
    check("R1 idle after reset", rdData, 8'h3C);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] arr;
      arr       = VEC[v][23:16];
      opErase   = VEC[v][32];
      loadedMsb = VEC[v][31];
      arrayData = arr;
      busy      = 1'b1;
      #1;
      check("R7 R4 immediate first status", rdData, VEC[v][15:8]);
      rdEn = 1'b1;
      tick(3);
      check("R3 held read no advance", rdData, VEC[v][15:8]);
      rdEn = 1'b0;
      tick(1);
      check(VEC[v][32] ? "R5 erase toggle" : "R2 R3 write toggle", rdData, VEC[v][7:0]);
      tick(2);
      check("R3 idle strobe no advance", rdData, VEC[v][7:0]);
      rdEn = 1'b1;
      tick(1);
      rdEn = 1'b0;
      tick(1);
      check("R3 second flip", rdData, VEC[v][15:8]);
      busy = 1'b0;
      #1;
      check("R8 settle on fall", rdData, {arr[7], 7'b0});
      tick(SETTLE);
      check("R8 settle last cycle", rdData, {arr[7], 7'b0});
      tick(1);
      check("R1 pass-through after settle", rdData, arr);
    end

    // Reads while idle must not disturb the first status value (R4)
    arrayData = 8'h66;
    for (int k = 0; k < 3; k++) begin
      rdEn = 1'b1;
      tick(1);
      rdEn = 1'b0;
      tick(1);
    end
    check("R1 idle reads pass-through", rdData, 8'h66);
    opErase   = 1'b0;
    loadedMsb = 1'b0;
    busy      = 1'b1;
    #1;
    check("R4 first toggle after idle reads", rdData, 8'hC0);
    rdEn = 1'b1;
    tick(1);
    rdEn = 1'b0;
    tick(1);
    check("R3 flip before re-entry test", rdData, 8'h80);

    // Re-raise busy inside the settling window (R10)
    busy = 1'b0;
    tick(2);
    check("R8 inside window", rdData, 8'h00);
    busy = 1'b1;
    #1;
    check("R10 window cut by busy", rdData, 8'hC0);
    busy = 1'b0;
    tick(SETTLE + 1);
    check("R1 back to array", rdData, 8'h66);

    // Reset during busy presets toggle (R9)
    busy = 1'b1;
    rdEn = 1'b1;
    tick(1);
    rdEn = 1'b0;
    tick(1);
    check("R3 flip pre-reset", rdData, 8'h80);
    rstN = 1'b0;
    #1;
    check("R9 reset presets toggle", rdData, 8'hC0);
    busy = 1'b0;
    tick(1);
    check("R9 reset no window", rdData, 8'h66);
    rstN = 1'b1;
    tick(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule